// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block turns a three-wire stereo PCM stream into parallel samples. The stream consists of a bit clock, a channel/frame clock and one data line. The whole block is clocked by the bit clock. Every data bit is sampled on a rising edge of that clock. Words arrive most significant bit first, in two's complement, and the left word of a frame always comes before the right one.

Four framings are supported, and a static 2-bit format input chooses between them:

- **Left-justified:** the word starts right at the channel-clock edge.
- **I2S:** the word starts one bit clock after the edge.
- **Right-justified:** the word is packed against the end of each half of a fixed 64-clock frame.
- **DSP/frame-sync:** the two words follow a single sync edge back to back.

A static word-length input picks 24, 20 or 16 bits. It is used by the right-justified and DSP framings.

Each completed word appears on a 24-bit output, aligned to the most significant bit, together with a one-cycle valid strobe for its channel. The block is meant to sit at the edge of an audio path. It feeds a downstream clock-domain crossing, which is outside this block.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low at a rising `bclk` edge, both data outputs are cleared to zero and both strobes go low (synchronous active-low reset).
- R2: With `fmt` = 01 (left-justified), `lrclk` high selects the left channel and low selects the right. The MSB is the bit sampled on the first rising edge at which the new `lrclk` level is seen.
- R3: With `fmt` = 00 (I2S), `lrclk` low selects the left channel and high selects the right. The MSB is sampled one `bclk` after the first edge that sees the new level.
- R4: With `fmt` = 10 (right-justified, 64 `bclk` per frame, `lrclk` high = left), capture starts 8, 12 or 16 `bclk` after the first edge of a half frame for `wl_sel` = 00, 01, 10 (24, 20, 16 bits). Earlier bits in the half frame are ignored.
- R5: With `fmt` = 11 (DSP), only a rising `lrclk` starts a frame, and falling edges have no effect. The left MSB is sampled one `bclk` after the first edge that sees `lrclk` high. The right word follows the left word at once. Both words have the length chosen by `wl_sel`, which is decoded as in R4.
- R6: In left-justified and I2S modes, only the first 24 bits of a channel slot are kept. Any further bits in that slot are discarded without effect.
- R7: If a left-justified or I2S slot ends before 24 bits have arrived, the partial word is emitted when the next slot begins. The bits that did not arrive read as zero.
- R8: 20- and 16-bit words are placed in the upper bits of the 24-bit output, and the unused low bits are zero.
- R9: Each channel word produces exactly one single-cycle strobe on its own channel, with the data output updated in the same cycle. A complete word is visible after the rising edge that samples its last bit. The data outputs hold their value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrclk | input | 1 | Channel select / frame sync clock |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 DSP |
| wl_sel | input | 2 | Word length: 00 = 24, 01 = 20, 10 = 16 bits (11 treated as 24) |
| left_data | output | 24 | Last left sample, MSB aligned |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_data | output | 24 | Last right sample, MSB aligned |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
The bench uses the default parameters: a 24-bit sample and a 64-clock right-justified frame. These give word lengths of 24, 20 and 16 bits and right-justified start offsets of 8, 12 and 16 clocks, and all three are exercised. The left-justified and I2S slots vary in length from 8 to 32 clocks. This covers truncated slots, partial slots and zero fill. Random garbage is placed in every bit position the receiver must ignore. DSP frames are run both with the minimum gap and with random idle padding.

// File: rtl/sair_pkg.sv
// Package: shared types for the serial audio receiver.
// Assumes the 2-bit format code is static while data flows.
package sair_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    localparam int DEF_SAMPLE_W   = 24;
    localparam int DEF_FRAME_BCLK = 64;

endpackage

// File: rtl/sair_frame_edge.sv
// Module: sair_frame_edge
// Derives the effective channel clock and the slot-start pulse.
// For I2S and DSP framing the channel clock is taken one bit clock late,
// so that for every format the MSB lines up with the detected edge.
// Assumes lrclk is synchronous to bclk.
module sair_frame_edge
    import sair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lrclk,
    input  logic [1:0] fmt,
    output logic       ws_eff,
    output logic       slot_start,
    output logic       ws_fall
);

    logic lr_q;
    logic lr_qq;
    logic delayed;
    logic ws_prev;
    logic ws_rise;

    // History of the channel clock: one and two cycles back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_q  <= 1'b0;
            lr_qq <= 1'b0;
        end else begin
            lr_q  <= lrclk;
            lr_qq <= lr_q;
        end
    end

    // Pick the current and previous level per format, then detect edges.
    always_comb begin
        delayed    = (fmt_e'(fmt) == FMT_I2S) || (fmt_e'(fmt) == FMT_DSP);
        ws_eff     = delayed ? lr_q  : lrclk;
        ws_prev    = delayed ? lr_qq : lr_q;
        ws_rise    = ws_eff && !ws_prev;
        ws_fall    = !ws_eff && ws_prev;
        slot_start = (fmt_e'(fmt) == FMT_DSP) ? ws_rise : (ws_rise || ws_fall);
    end

endmodule

// File: rtl/sair_slot_counter.sv
// Module: sair_slot_counter
// Counts bit positions since the last slot start; position 0 is the cycle
// of the start pulse itself. Saturates at its maximum so a missing edge
// never wraps back into a capture window. Resets to the saturated value.
module sair_slot_counter #(
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos_q;

    // Next position: restart on a slot start, otherwise step and saturate.
    always_comb begin
        if (slot_start)
            pos = '0;
        else if (pos_q == POS_MAX)
            pos = POS_MAX;
        else
            pos = pos_q + POS_W'(1);
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= POS_MAX;
        else
            pos_q <= pos;
    end

endmodule

// File: rtl/sair_word_assembler.sv
// Module: sair_word_assembler
// Places each sampled bit straight into its MSB-aligned position, using the
// slot position and a per-format capture window. It emits a word on its
// last bit, or flushes a partial word at the next slot start.
// Assumes fmt and wl_sel are static during a stream.
module sair_word_assembler
    import sair_pkg::*;
#(
    parameter int SAMPLE_W    = 24,
    parameter int FRAME_BCLKS = 64,
    parameter int POS_W       = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wl_sel,
    input  logic                sdata,
    input  logic                ws,
    input  logic                slot_start,
    input  logic [POS_W-1:0]    pos,
    output logic [SAMPLE_W-1:0] left_data,
    output logic                left_valid,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                right_valid
);

    localparam int IDX_W = $clog2(SAMPLE_W);
    localparam logic [POS_W-1:0] HALF_FRAME = POS_W'(FRAME_BCLKS / 2);
    localparam logic [POS_W-1:0] RJ_MIN_LO  = POS_W'(FRAME_BCLKS / 2 - SAMPLE_W);

    logic [POS_W-1:0]    wl;
    logic [POS_W-1:0]    win_lo;
    logic [POS_W-1:0]    lim;
    logic [POS_W-1:0]    k;
    logic [IDX_W-1:0]    idx;
    logic                take;
    logic                last;
    logic                is_left;
    logic                flush;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] acc;
    logic                acc_left;
    logic                busy;
    logic [POS_W-1:0]    cnt;

    // Decode the word-length selector.
    always_comb begin
        case (wl_sel)
            2'b01:   wl = POS_W'(SAMPLE_W - 4);
            2'b10:   wl = POS_W'(SAMPLE_W - 8);
            default: wl = POS_W'(SAMPLE_W);
        endcase
    end

    // Capture window and channel for the current slot position.
    always_comb begin
        win_lo  = '0;
        lim     = POS_W'(SAMPLE_W);
        is_left = ws;
        case (fmt_e'(fmt))
            FMT_LJ:  is_left = ws;
            FMT_I2S: is_left = !ws;
            FMT_RJ: begin
                win_lo  = HALF_FRAME - wl;
                lim     = wl;
                is_left = ws;
            end
            default: begin
                lim = wl;
                if (pos < wl) begin
                    is_left = 1'b1;
                end else begin
                    win_lo  = wl;
                    is_left = 1'b0;
                end
            end
        endcase
    end

    // Bit index within the word, and the word with the current bit inserted.
    always_comb begin
        k     = pos - win_lo;
        take  = (pos >= win_lo) && (k < lim);
        last  = take && (k == lim - POS_W'(1));
        idx   = IDX_W'(SAMPLE_W - 1) - k[IDX_W-1:0];
        word  = (k == '0) ? '0 : acc;
        if (take)
            word[idx] = sdata;
        flush = slot_start && busy;
    end

    // Accumulator and word-in-progress tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc      <= '0;
            acc_left <= 1'b0;
            busy     <= 1'b0;
            cnt      <= '0;
        end else if (take) begin
            acc      <= word;
            acc_left <= is_left;
            busy     <= !last;
            cnt      <= last ? '0 : k + POS_W'(1);
        end else if (flush) begin
            busy <= 1'b0;
            cnt  <= '0;
        end
    end

    // Output registers: a partial word flush wins over a normal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_data   <= '0;
            left_valid  <= 1'b0;
            right_data  <= '0;
            right_valid <= 1'b0;
        end else begin
            left_valid  <= 1'b0;
            right_valid <= 1'b0;
            if (flush) begin
                if (acc_left) begin
                    left_data  <= acc;
                    left_valid <= 1'b1;
                end else begin
                    right_data  <= acc;
                    right_valid <= 1'b1;
                end
            end else if (last) begin
                if (is_left) begin
                    left_data  <= word;
                    left_valid <= 1'b1;
                end else begin
                    right_data  <= word;
                    right_valid <= 1'b1;
                end
            end
        end
    end

    // R6
    bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= POS_W'(SAMPLE_W));

    // R4
    rj_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_e'(fmt) == FMT_RJ && take) |-> (pos >= RJ_MIN_LO));

    // R9
    left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_valid |=> !left_valid);

    // R9
    right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        right_valid |=> !right_valid);

endmodule

// File: rtl/serial_audio_rx.sv
// Module: serial_audio_rx (top)
// Three-wire serial audio receiver with four framing formats.
// Everything runs in the bit-clock domain, and the configuration inputs
// are assumed static. The outputs are MSB-aligned samples with one-cycle
// strobes per channel.
module serial_audio_rx
    import sair_pkg::*;
#(
    parameter int SAMPLE_W    = DEF_SAMPLE_W,
    parameter int FRAME_BCLKS = DEF_FRAME_BCLK,
    localparam int POS_W      = $clog2(FRAME_BCLKS) + 1
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrclk,
    input  logic                sdata,
    input  logic [1:0]          fmt,
    input  logic [1:0]          wl_sel,
    output logic [SAMPLE_W-1:0] left_data,
    output logic                left_valid,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                right_valid
);

    logic             ws_eff;
    logic             slot_start;
    logic             ws_fall;
    logic [POS_W-1:0] slot_pos;

    sair_frame_edge u_edge (
        .clk        (bclk),
        .rst_n      (rst_n),
        .lrclk      (lrclk),
        .fmt        (fmt),
        .ws_eff     (ws_eff),
        .slot_start (slot_start),
        .ws_fall    (ws_fall)
    );

    sair_slot_counter #(.POS_W(POS_W)) u_cnt (
        .clk        (bclk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .pos        (slot_pos)
    );

    sair_word_assembler #(
        .SAMPLE_W    (SAMPLE_W),
        .FRAME_BCLKS (FRAME_BCLKS),
        .POS_W       (POS_W)
    ) u_asm (
        .clk         (bclk),
        .rst_n       (rst_n),
        .fmt         (fmt),
        .wl_sel      (wl_sel),
        .sdata       (sdata),
        .ws          (ws_eff),
        .slot_start  (slot_start),
        .pos         (slot_pos),
        .left_data   (left_data),
        .left_valid  (left_valid),
        .right_data  (right_data),
        .right_valid (right_valid)
    );

    // R5
    dsp_fall_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (fmt_e'(fmt) == FMT_DSP && ws_fall) |-> (slot_pos != '0));

endmodule

// File: tb/sim_serial_audio_rx.sv
// Bench: builds bit streams per format, with expected words kept in queues,
// and compares every strobe against them. Stimulus is seeded random plus
// directed slot lengths.
module sim_serial_audio_rx;

    localparam int CLK_PERIOD = 10;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt = 2'b01;
    logic [1:0]  wl_sel = 2'b00;
    logic [23:0] left_data;
    logic        left_valid;
    logic [23:0] right_data;
    logic        right_valid;

    int checks = 0;
    int errors = 0;
    string req_tag = "R1";

    bit ws_a [0:2047];
    bit sd_a [0:2047];
    int n = 0;
    logic [23:0] exp_l [$];
    logic [23:0] exp_r [$];

    serial_audio_rx u0 (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .lrclk       (lrclk),
        .sdata       (sdata),
        .fmt         (fmt),
        .wl_sel      (wl_sel),
        .left_data   (left_data),
        .left_valid  (left_valid),
        .right_data  (right_data),
        .right_valid (right_valid)
    );

    always #(CLK_PERIOD / 2) bclk = ~bclk;

    task automatic check(input bit ok, input string tag, input logic [23:0] act,
                         input logic [23:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] wmask(input int len);
        return 24'hFFFFFF << (24 - len);
    endfunction

    // Compare each strobe with the next expected word of its channel (R9).
    always @(negedge bclk) begin
        if (rst_n) begin
            if (left_valid) begin
                if (exp_l.size() == 0)
                    check(1'b0, {req_tag, " R9 unexpected left"}, left_data, 24'h0);
                else
                    check(left_data == exp_l[0], {req_tag, " left word"}, left_data, exp_l[0]);
                if (exp_l.size() != 0) void'(exp_l.pop_front());
            end
            if (right_valid) begin
                if (exp_r.size() == 0)
                    check(1'b0, {req_tag, " R9 unexpected right"}, right_data, 24'h0);
                else
                    check(right_data == exp_r[0], {req_tag, " right word"}, right_data, exp_r[0]);
                if (exp_r.size() != 0) void'(exp_r.pop_front());
            end
        end
    end

    // Left-justified / I2S slot of len bits; dly = 1 for I2S.
    task automatic add_js_slot(input bit lvl, input int len, input bit left, input int dly);
        logic [31:0] sb;
        logic [23:0] e;
        sb = $urandom;
        for (int k = 0; k < len; k++) begin
            ws_a[n + k] = lvl;
            sd_a[n + k + dly] = sb[31 - k];
        end
        e = sb[31:8];
        if (len < 24) e = e & wmask(len);
        if (left) exp_l.push_back(e); else exp_r.push_back(e);
        n += len;
    endtask

    // Right-justified frame: two 32-clock halves with garbage before the word.
    task automatic add_rj_frame(input int wlen);
        for (int ch = 0; ch < 2; ch++) begin
            logic [23:0] v;
            logic [31:0] g;
            v = 24'($urandom) & wmask(wlen);
            g = $urandom;
            for (int k = 0; k < 32; k++) begin
                ws_a[n + k] = (ch == 0);
                if (k < 32 - wlen) sd_a[n + k] = g[k];
                else sd_a[n + k] = v[23 - (k - (32 - wlen))];
            end
            if (ch == 0) exp_l.push_back(v); else exp_r.push_back(v);
            n += 32;
        end
    endtask

    // DSP frame: one-cycle sync, then left and right words back to back.
    task automatic add_dsp_frame(input int wlen, input int extra);
        logic [23:0] lw;
        logic [23:0] rw;
        logic [31:0] g;
        int f;
        f = 2 * wlen + 1 + extra;
        lw = 24'($urandom) & wmask(wlen);
        rw = 24'($urandom) & wmask(wlen);
        g = $urandom;
        for (int t = 0; t < f; t++) begin
            ws_a[n + t] = (t == 0);
            if (t >= 1 && t <= wlen) sd_a[n + t] = lw[23 - (t - 1)];
            else if (t > wlen && t <= 2 * wlen) sd_a[n + t] = rw[23 - (t - 1 - wlen)];
            else sd_a[n + t] = g[t % 32];
        end
        exp_l.push_back(lw);
        exp_r.push_back(rw);
        n += f;
    endtask

    task automatic start_phase(input logic [1:0] f, input logic [1:0] w, input string tag);
        @(negedge bclk);
        rst_n = 1'b0; lrclk = 1'b0; sdata = 1'b0; fmt = f; wl_sel = w;
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;
        repeat (2) @(negedge bclk);
        req_tag = tag;
        n = 0;
        for (int i = 0; i < 2048; i++) begin ws_a[i] = 1'b0; sd_a[i] = 1'b0; end
    endtask

    task automatic play_phase(input int dly);
        for (int i = 0; i < n + dly; i++) begin
            @(negedge bclk);
            lrclk = (i < n) ? ws_a[i] : ws_a[n - 1];
            sdata = sd_a[i];
        end
        @(negedge bclk);
        sdata = 1'b0;
        repeat (40) @(negedge bclk);
        check(exp_l.size() == 0 && exp_r.size() == 0, {req_tag, " R9 all words emitted"},
              24'(exp_l.size() + exp_r.size()), 24'h0);
        exp_l.delete();
        exp_r.delete();
    endtask

    initial begin
        repeat (150000) @(posedge bclk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1954));
        // R1 reset state
        repeat (4) @(negedge bclk);
        check(left_data == 24'h0 && !left_valid, "R1 left reset", left_data, 24'h0);
        check(right_data == 24'h0 && !right_valid, "R1 right reset", right_data, 24'h0);

        // R2 left-justified, with truncation (R6) and partial slots (R7)
        start_phase(2'b01, 2'b00, "R2 R6 R7");
        add_js_slot(1'b1, 32, 1'b1, 0); add_js_slot(1'b0, 32, 1'b0, 0);
        add_js_slot(1'b1, 24, 1'b1, 0); add_js_slot(1'b0, 24, 1'b0, 0);
        add_js_slot(1'b1, 25, 1'b1, 0); add_js_slot(1'b0, 20, 1'b0, 0);
        add_js_slot(1'b1, 16, 1'b1, 0); add_js_slot(1'b0, 16, 1'b0, 0);
        for (int s = 0; s < 12; s++) begin
            add_js_slot(1'b1, 8 + int'($urandom % 25), 1'b1, 0);
            add_js_slot(1'b0, 8 + int'($urandom % 25), 1'b0, 0);
        end
        add_js_slot(1'b1, 32, 1'b1, 0); add_js_slot(1'b0, 32, 1'b0, 0);
        play_phase(0);

        // R3 I2S: inverted polarity, one-clock MSB delay; first slot is right
        start_phase(2'b00, 2'b00, "R3 R6 R7");
        add_js_slot(1'b1, 32, 1'b0, 1);
        add_js_slot(1'b0, 32, 1'b1, 1); add_js_slot(1'b1, 25, 1'b0, 1);
        add_js_slot(1'b0, 18, 1'b1, 1); add_js_slot(1'b1, 24, 1'b0, 1);
        for (int s = 0; s < 12; s++) begin
            add_js_slot(1'b0, 8 + int'($urandom % 25), 1'b1, 1);
            add_js_slot(1'b1, 8 + int'($urandom % 25), 1'b0, 1);
        end
        add_js_slot(1'b0, 32, 1'b1, 1); add_js_slot(1'b1, 32, 1'b0, 1);
        play_phase(1);

        // R4 right-justified, all three word lengths (R8 alignment)
        for (int w = 0; w < 3; w++) begin
            start_phase(2'b10, 2'(w), "R4 R8");
            for (int fr = 0; fr < 6; fr++) add_rj_frame(24 - 4 * w);
            play_phase(0);
        end

        // R5 DSP frame sync, all three word lengths (R8 alignment)
        for (int w = 0; w < 3; w++) begin
            start_phase(2'b11, 2'(w), "R5 R8");
            add_dsp_frame(24 - 4 * w, 0);
            add_dsp_frame(24 - 4 * w, 0);
            for (int fr = 0; fr < 4; fr++) add_dsp_frame(24 - 4 * w, int'($urandom % 10));
            play_phase(0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule